// File: doc/BRIEF.md
# Rectangle Blit Engine

This block moves or paints rectangles of bytes in a byte-addressed memory. Software sets up the job through a small byte-wide register file. It programs the rectangle size, the two line pitches, the two start addresses, a mode byte, a raster-op byte and the colour bytes. It then writes a start bit and polls a busy flag until the job is done. The memory sits outside the block behind a single-port interface. Reads have one cycle of latency.

There are two kinds of job. A copy moves a rectangle from source to destination. It runs either with rising addresses or, when the backward bit is set, with falling addresses that start from the last byte. With the right direction chosen, overlapping rectangles come out intact. A fill writes a solid colour into the destination. The 1, 2 or 4 byte colour is repeated across each line according to the pixel depth taken from the mode byte.

Top module: `blit_engine`

## Requirements
- R1: The configuration bytes can be written and read back at these offsets. Width is at 0x00/0x01 and height at 0x02/0x03 (low, high). Source pitch is at 0x04/0x05 and destination pitch at 0x06/0x07 (low, high). The source address is at 0x08/0x09/0x0A and the destination address at 0x0C/0x0D/0x0E (low, middle, high). Mode is at 0x0B and raster-op at 0x0F. Colour byte k has its foreground at 0x10+2k and its background at 0x11+2k.
- R2: Width holds the byte count per line minus one, and height holds the line count minus one. Both the low and the high byte take part.
- R3: With mode bit 7 clear and bit 0 clear, a copy walks both rectangles upward. Each pointer moves from the last byte of a line to the first byte of the next line using its own pitch.
- R4: With mode bit 0 set, a copy starts from the programmed addresses, which name the last byte of each rectangle, and walks both pointers downward. The result of an overlapping copy equals a copy taken from a snapshot of the source.
- R5: With mode bit 7 set, the job is a fill of the destination with the foreground colour. Mode bits 5:4 give the bytes per pixel: 00 is 1 byte (0xC0), 01 is 2 bytes (0xD0) and 11 is 4 bytes (0xF0). Byte j of a line receives colour byte (j mod pixel size). Fills always walk forward, and background bytes have no effect.
- R6: Writing 0x18 with bit 1 set while idle starts a job. The busy flag (bit 0 of 0x18) reads 1 from the next cycle. It stays 1 for exactly N cycles for a fill of N bytes and 2N cycles for a copy of N bytes, then falls.
- R7: A start written while busy is ignored. The job keeps its length and writes nothing extra.
- R8: Memory is read or written only while busy, and no byte outside the destination rectangle changes.
- R9: After reset all configuration bytes read 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_re | output | 1 | Memory read request; data returns next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
On every cycle the assertions check several things. Busy rises after an idle start and falls right after the last write. Memory stays quiet while idle. Each copy write follows a read. Pointers step by exactly one inside a line in the chosen direction, and the line counter never passes the programmed height. Only the bench scenarios can show what a job does to memory as a whole. That covers the bytes of overlapping copies in both directions, line skips with unequal pitches, and the byte order of 16- and 32-bit fills. They also show that nothing outside the rectangle is touched and that a second start during a job leaves its length alone.

// File: rtl/blit_pkg.sv
package blit_pkg;
   localparam int unsigned NUM_CFG = 24;
   localparam logic [4:0] OFS_WID_LO = 5'h00;
   localparam logic [4:0] OFS_WID_HI = 5'h01;
   localparam logic [4:0] OFS_HGT_LO = 5'h02;
   localparam logic [4:0] OFS_HGT_HI = 5'h03;
   localparam logic [4:0] OFS_SPI_LO = 5'h04;
   localparam logic [4:0] OFS_SPI_HI = 5'h05;
   localparam logic [4:0] OFS_DPI_LO = 5'h06;
   localparam logic [4:0] OFS_DPI_HI = 5'h07;
   localparam logic [4:0] OFS_SRC_0  = 5'h08;
   localparam logic [4:0] OFS_SRC_1  = 5'h09;
   localparam logic [4:0] OFS_SRC_2  = 5'h0A;
   localparam logic [4:0] OFS_MODE   = 5'h0B;
   localparam logic [4:0] OFS_DST_0  = 5'h0C;
   localparam logic [4:0] OFS_DST_1  = 5'h0D;
   localparam logic [4:0] OFS_DST_2  = 5'h0E;
   localparam logic [4:0] OFS_ROP    = 5'h0F;
   localparam logic [4:0] OFS_COLOR  = 5'h10;
   localparam logic [4:0] OFS_CTRL   = 5'h18;

   localparam int unsigned CTRL_GO_BIT   = 1;
   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned MODE_BACK_BIT = 0;
   localparam int unsigned MODE_FILL_BIT = 7;
   localparam int unsigned MODE_DEP_LSB  = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_FILL
   } blit_state_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DIM_W     = 16,
   parameter int COLOR_BYT = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [4:0]             reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   input  logic                   busy_i,
   output logic                   start_req_o,
   output logic [DIM_W-1:0]       width_o,
   output logic [DIM_W-1:0]       height_o,
   output logic [DIM_W-1:0]       src_pitch_o,
   output logic [DIM_W-1:0]       dst_pitch_o,
   output logic [ADDR_W-1:0]      src_base_o,
   output logic [ADDR_W-1:0]      dst_base_o,
   output logic                   back_mode_o,
   output logic                   fill_mode_o,
   output logic [1:0]             depth_o,
   output logic [8*COLOR_BYT-1:0] fg_color_o
);
   if (DIM_W < 2 || DIM_W > 16) begin : g_bad_dim
      $error("blit_regs: DIM_W must lie in 2..16");
   end
   if (ADDR_W < DIM_W || ADDR_W > 24) begin : g_bad_addr
      $error("blit_regs: ADDR_W must lie in DIM_W..24");
   end
   if (COLOR_BYT != 4) begin : g_bad_col
      $error("blit_regs: COLOR_BYT must be 4");
   end

   logic [7:0] cfg_q [NUM_CFG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
      end else if (reg_we && (reg_addr < 5'(NUM_CFG))) begin
         cfg_q[reg_addr] <= reg_wdata;
      end
   end

   always_comb begin
      if (reg_addr < 5'(NUM_CFG))  reg_rdata = cfg_q[reg_addr];
      else if (reg_addr == OFS_CTRL) reg_rdata = 8'(busy_i) << STAT_BUSY_BIT;
      else                           reg_rdata = '0;
   end

   assign start_req_o = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];

   logic [15:0] wid16, hgt16, spi16, dpi16;
   logic [23:0] src24, dst24;
   assign wid16 = {cfg_q[OFS_WID_HI], cfg_q[OFS_WID_LO]};
   assign hgt16 = {cfg_q[OFS_HGT_HI], cfg_q[OFS_HGT_LO]};
   assign spi16 = {cfg_q[OFS_SPI_HI], cfg_q[OFS_SPI_LO]};
   assign dpi16 = {cfg_q[OFS_DPI_HI], cfg_q[OFS_DPI_LO]};
   assign src24 = {cfg_q[OFS_SRC_2], cfg_q[OFS_SRC_1], cfg_q[OFS_SRC_0]};
   assign dst24 = {cfg_q[OFS_DST_2], cfg_q[OFS_DST_1], cfg_q[OFS_DST_0]};

   assign width_o     = wid16[DIM_W-1:0];
   assign height_o    = hgt16[DIM_W-1:0];
   assign src_pitch_o = spi16[DIM_W-1:0];
   assign dst_pitch_o = dpi16[DIM_W-1:0];
   assign src_base_o  = src24[ADDR_W-1:0];
   assign dst_base_o  = dst24[ADDR_W-1:0];

   assign back_mode_o = cfg_q[OFS_MODE][MODE_BACK_BIT];
   assign fill_mode_o = cfg_q[OFS_MODE][MODE_FILL_BIT];
   assign depth_o     = cfg_q[OFS_MODE][MODE_DEP_LSB +: 2];

   for (genvar k = 0; k < COLOR_BYT; k++) begin : g_fg
      assign fg_color_o[8*k +: 8] = cfg_q[OFS_COLOR + 5'(2*k)];
   end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
   parameter int ADDR_W = 24,
   parameter int DIM_W  = 16,
   parameter int PH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              back_i,
   input  logic [DIM_W-1:0]  width_i,
   input  logic [DIM_W-1:0]  height_i,
   input  logic [DIM_W-1:0]  src_pitch_i,
   input  logic [DIM_W-1:0]  dst_pitch_i,
   input  logic [ADDR_W-1:0] src_base_i,
   input  logic [ADDR_W-1:0] dst_base_i,
   output logic [ADDR_W-1:0] src_ptr_o,
   output logic [ADDR_W-1:0] dst_ptr_o,
   output logic [PH_W-1:0]   phase_o,
   output logic              last_o
);
   localparam int NCH = 2;

   if (PH_W > DIM_W) begin : g_bad_ph
      $error("blit_walker: PH_W exceeds DIM_W");
   end

   logic [DIM_W-1:0] col_q, row_q;
   logic             line_end;

   assign line_end = (col_q == width_i);
   assign last_o   = line_end && (row_q == height_i);
   assign phase_o  = col_q[PH_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (load_i) begin
         col_q <= '0;
         row_q <= '0;
      end else if (step_i) begin
         if (line_end) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   logic [NCH-1:0][ADDR_W-1:0] base_v;
   logic [NCH-1:0][DIM_W-1:0]  pitch_v;
   logic [ADDR_W-1:0]          wid_ext;
   assign base_v  = {dst_base_i, src_base_i};
   assign pitch_v = {dst_pitch_i, src_pitch_i};
   assign wid_ext = ADDR_W'(width_i);

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [ADDR_W-1:0] ptr_q;
      logic [ADDR_W-1:0] pitch_ext;
      assign pitch_ext = ADDR_W'(pitch_v[ch]);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr_q <= '0;
         end else if (load_i) begin
            ptr_q <= base_v[ch];
         end else if (step_i) begin
            if (line_end) ptr_q <= back_i ? (ptr_q - pitch_ext + wid_ext)
                                          : (ptr_q + pitch_ext - wid_ext);
            else          ptr_q <= back_i ? (ptr_q - 1'b1) : (ptr_q + 1'b1);
         end
      end
   end

   assign src_ptr_o = g_ch[0].ptr_q;
   assign dst_ptr_o = g_ch[1].ptr_q;

   // R3: inside a line the forward pointer rises by one
   a_r3_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !back_i && !line_end && !load_i) |=> (dst_ptr_o == $past(dst_ptr_o) + 1'b1));
   // R4: inside a line the backward pointer falls by one
   a_r4_back_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && back_i && !line_end && !load_i) |=> (dst_ptr_o == $past(dst_ptr_o) - 1'b1));
   // R2: the line counter never passes the programmed height
   a_r2_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (row_q <= height_i));
endmodule

// File: rtl/blit_colorexp.sv
module blit_colorexp #(
   parameter int MAX_BYTES = 4,
   parameter int SEL_W     = $clog2(MAX_BYTES)
) (
   input  logic [1:0]             depth_i,
   input  logic [SEL_W-1:0]       phase_i,
   input  logic [8*MAX_BYTES-1:0] color_i,
   output logic [7:0]             byte_o
);
   if (MAX_BYTES != 4) begin : g_bad_bytes
      $error("blit_colorexp: depth codes cover exactly 4 bytes");
   end

   logic [SEL_W-1:0] mask, sel;
   always_comb begin
      unique case (depth_i)
         2'b00:   mask = '0;
         2'b01:   mask = SEL_W'(1);
         default: mask = '1;
      endcase
      sel    = phase_i & mask;
      byte_o = color_i[8*sel +: 8];
   end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DIM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [4:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int COL_BYT = 4;
   localparam int PH_W    = $clog2(COL_BYT);

   blit_state_e       state_q;
   logic              busy, start_req, load, step, last;
   logic              back_mode, fill_mode;
   logic [1:0]        depth;
   logic [DIM_W-1:0]  width, height, src_pitch, dst_pitch;
   logic [ADDR_W-1:0] src_base, dst_base, src_ptr, dst_ptr;
   logic [PH_W-1:0]   phase;
   logic [8*COL_BYT-1:0] fg_color;
   logic [7:0]        color_byte;

   assign busy = (state_q != ST_IDLE);
   assign load = start_req && !busy;

   blit_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .COLOR_BYT(COL_BYT)) regs_i (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .busy_i(busy), .start_req_o(start_req),
      .width_o(width), .height_o(height),
      .src_pitch_o(src_pitch), .dst_pitch_o(dst_pitch),
      .src_base_o(src_base), .dst_base_o(dst_base),
      .back_mode_o(back_mode), .fill_mode_o(fill_mode),
      .depth_o(depth), .fg_color_o(fg_color)
   );

   blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PH_W(PH_W)) walk_i (
      .clk, .rst_n, .load_i(load), .step_i(step),
      .back_i(back_mode && !fill_mode),
      .width_i(width), .height_i(height),
      .src_pitch_i(src_pitch), .dst_pitch_i(dst_pitch),
      .src_base_i(src_base), .dst_base_i(dst_base),
      .src_ptr_o(src_ptr), .dst_ptr_o(dst_ptr),
      .phase_o(phase), .last_o(last)
   );

   blit_colorexp #(.MAX_BYTES(COL_BYT)) cexp_i (
      .depth_i(depth), .phase_i(phase), .color_i(fg_color), .byte_o(color_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (load) state_q <= fill_mode ? ST_FILL : ST_READ;
            ST_READ:  state_q <= ST_WRITE;
            ST_WRITE: state_q <= last ? ST_IDLE : ST_READ;
            ST_FILL:  if (last) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_re    = (state_q == ST_READ);
   assign mem_we    = (state_q == ST_WRITE) || (state_q == ST_FILL);
   assign step      = mem_we;
   assign mem_addr  = mem_re ? src_ptr : dst_ptr;
   assign mem_wdata = (state_q == ST_FILL) ? color_byte : mem_rdata;

   // R6: an accepted start makes the engine busy on the next cycle
   a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy) |=> busy);
   // R6: the final write returns the engine to idle
   a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> !busy);
   // R7: a start during a job neither ends nor restarts it
   a_r7_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_req && !(step && last)) |=> busy);
   // R8: no memory traffic while idle
   a_r8_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_re || mem_we));
   // R3: each copy write uses data read in the previous cycle
   a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !fill_mode) |-> $past(mem_re));
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [23:0] mem_addr;
   logic        mem_re, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   always #5 clk = ~clk;

   blit_engine dut_i (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_addr, .mem_re, .mem_we, .mem_wdata, .mem_rdata
   );

   logic [7:0] ram [4096];
   logic [7:0] exp_mem [4096];
   logic [7:0] ram_rd = '0;
   logic       preload = 1'b1;
   assign mem_rdata = ram_rd;

   function automatic logic [7:0] seed_byte(int i);
      return 8'((i * 37 + 11) ^ (i >> 4));
   endfunction

   always @(posedge clk) begin
      if (preload) begin
         for (int i = 0; i < 4096; i++) ram[i] <= seed_byte(i);
      end else begin
         if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
         if (mem_re) ram_rd <= ram[mem_addr[11:0]];
      end
   end

   int n_checks = 0;
   int n_fails  = 0;

   task automatic report_end();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   task automatic check_val(string tag, string what, int act, int exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic program_job(int w, int h, int sp, int dp, int src, int dst,
                              logic [7:0] mode, logic [31:0] color);
      wr(5'h00, 8'(w - 1));  wr(5'h01, 8'((w - 1) >> 8));
      wr(5'h02, 8'(h - 1));  wr(5'h03, 8'((h - 1) >> 8));
      wr(5'h04, 8'(sp));     wr(5'h05, 8'(sp >> 8));
      wr(5'h06, 8'(dp));     wr(5'h07, 8'(dp >> 8));
      wr(5'h08, 8'(src));    wr(5'h09, 8'(src >> 8)); wr(5'h0A, 8'(src >> 16));
      wr(5'h0C, 8'(dst));    wr(5'h0D, 8'(dst >> 8)); wr(5'h0E, 8'(dst >> 16));
      wr(5'h0B, mode);       wr(5'h0F, 8'h0D);
      for (int k = 0; k < 4; k++) begin
         wr(5'(16 + 2 * k), color[8 * k +: 8]);
         wr(5'(17 + 2 * k), ~color[8 * k +: 8]);
      end
   endtask

   // start, then count cycles with busy read back as 1; optional second start
   task automatic go_and_time(output int cyc, input int inject_at);
      @(negedge clk);
      reg_addr = 5'h18; reg_wdata = 8'h02; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      cyc = 0;
      while (reg_rdata[0] && cyc < 5000) begin
         cyc++;
         if (cyc == inject_at) reg_we = 1'b1;
         @(negedge clk);
         reg_we = 1'b0;
      end
   endtask

   task automatic compare_mem(string tag);
      int bad = 0;
      int first = 0;
      for (int i = 0; i < 4096; i++) begin
         if (ram[i] !== exp_mem[i]) begin
            if (bad == 0) first = i;
            bad++;
         end
      end
      n_checks++;
      if (bad != 0) begin
         n_fails++;
         $display("FAIL %s memory: %0d bytes differ, first 0x%03h actual %02h expected %02h",
                  tag, bad, first, ram[first], exp_mem[first]);
      end
   endtask

   task automatic ref_copy(int src, int dst, int w, int h, int sp, int dp);
      logic [7:0] snap [4096];
      for (int i = 0; i < 4096; i++) snap[i] = exp_mem[i];
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++)
            exp_mem[(dst + r * dp + c) % 4096] = snap[(src + r * sp + c) % 4096];
   endtask

   task automatic t_copy(string tag, int src, int dst, int w, int h, int sp, int dp, bit back);
      int cyc;
      int s = back ? src + (h - 1) * sp + (w - 1) : src;
      int d = back ? dst + (h - 1) * dp + (w - 1) : dst;
      program_job(w, h, sp, dp, s, d, back ? 8'h01 : 8'h00, 32'h0);
      go_and_time(cyc, 0);
      check_val("R6", "copy busy cycles", cyc, 2 * w * h);
      ref_copy(src, dst, w, h, sp, dp);
      compare_mem(tag);
   endtask

   task automatic t_fill(string tag, int dst, int w, int h, int dp,
                         logic [7:0] mode, int bpp, logic [31:0] color);
      int cyc;
      program_job(w, h, 16, dp, 0, dst, mode, color);
      go_and_time(cyc, 0);
      check_val("R6", "fill busy cycles", cyc, w * h);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++)
            exp_mem[(dst + r * dp + c) % 4096] = color[8 * (c % bpp) +: 8];
      compare_mem(tag);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(5'h18, v); check_val("R9", "status after reset", v, 0);
      rd(5'h0A, v); check_val("R9", "src high after reset", v, 0);
      rd(5'h15, v); check_val("R9", "colour after reset", v, 0);
      compare_mem("R9 R8");
   endtask

   task automatic t_readback();
      logic [7:0] v;
      wr(5'h0F, 8'h0D); rd(5'h0F, v); check_val("R1", "raster-op readback", v, 8'h0D);
      wr(5'h0D, 8'hA5); rd(5'h0D, v); check_val("R1", "dst middle readback", v, 8'hA5);
      wr(5'h17, 8'h3C); rd(5'h17, v); check_val("R1", "bg byte 3 readback", v, 8'h3C);
   endtask

   task automatic t_restart();
      int cyc;
      program_job(8, 1, 16, 16, 0, 12'hC00, 8'hC0, 32'h0000_005A);
      go_and_time(cyc, 3);
      check_val("R7", "busy cycles with second start", cyc, 8);
      for (int c = 0; c < 8; c++) exp_mem[12'hC00 + c] = 8'h5A;
      compare_mem("R7 R8");
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) exp_mem[i] = seed_byte(i);
      repeat (3) @(negedge clk);
      preload = 1'b0;
      rst_n   = 1'b1;
      t_reset();
      t_readback();
      t_copy("R3 R2 R8", 12'h100, 12'h300, 4, 3, 16, 16, 1'b0);
      t_copy("R3 unequal pitch", 12'h180, 12'h500, 5, 4, 8, 20, 1'b0);
      t_copy("R3 overlap left", 12'h805, 12'h800, 10, 2, 16, 16, 1'b0);
      t_copy("R4 overlap right", 12'h600, 12'h603, 8, 2, 32, 32, 1'b1);
      t_copy("R4 overlap down", 12'h700, 12'h721, 6, 4, 16, 16, 1'b1);
      t_fill("R5 8bpp", 12'h900, 7, 3, 16, 8'hC0, 1, 32'h4433_2211);
      t_fill("R5 16bpp", 12'hA00, 8, 2, 12, 8'hD0, 2, 32'h4433_2211);
      t_fill("R5 32bpp", 12'hB00, 12, 3, 16, 8'hF0, 4, 32'h8877_6655);
      t_fill("R2 wide line", 12'hD00, 300, 1, 16, 8'hC0, 1, 32'h0000_00E7);
      t_restart();
      report_end();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report_end();
   end
endmodule